// File: doc/BRIEF.md
# Bit-Oriented Message Codec for a 4 kbit/s T1 Data Link

This block carries short repeating codes over the facility data link of an extended-superframe T1 line. On the transmit side it produces, one bit per strobe, an endless 16-bit codeword. The codeword is a run of eight ones followed by a byte of the form `0 m5 m4 m3 m2 m1 m0 0`. The six `m` bits come from a transmit message register that software writes. Sending starts and stops with an enable bit.

On the receive side the block finds byte alignment by hunting for the run of ones. Each byte that follows the run is a candidate, and the block keeps the last ten candidates. A code is accepted only when the newest candidate agrees with at least seven of those ten. An accepted code that differs from the one already held is written to the receive message register. In that case the block can raise a one-clock interrupt pulse, which a mask bit can suppress. The block does not interpret the meaning of a code.

Top module: `bom_codec`

## Requirements
- R1: After reset, `tx_bit` is 1, `rx_msg` is 0 and `irq` is 0, and the receive history holds no valid entry.
- R2: While the sender is idle, `tx_bit` is 1 and the codeword position returns to its start. The sender becomes idle on the clock after `tx_en` is sampled low and becomes active on the clock after `tx_en` is sampled high.
- R3: While active, each `tx_bit_stb` moves one position through the 16-bit codeword, and the codeword repeats without a gap. The first eight positions are 1. Position 8 is 0. Positions 9 to 14 carry message bits 5 down to 0, most significant first. Position 15 is 0.
- R4: A write on `tx_msg_wr` changes only codewords that begin after the write. A write in the same clock as the strobe of position 15 takes effect one codeword later, and no codeword ever mixes two messages.
- R5: On receive, the first 0 after at least eight consecutive sampled 1s begins a candidate byte made of that 0 and the next seven sampled bits, first bit most significant. A run of fewer than eight ones does not align the receiver. A candidate whose last bit is 1 is invalid and counts as a non-matching history entry.
- R6: A valid candidate is accepted when, counting it, at least 7 of the 10 newest candidates are valid and carry the same six-bit code, which is bits 6 to 1 of the byte. With fewer matches nothing changes.
- R7: An accepted code is written to `rx_msg` only if no code has yet been loaded or if it differs from the current `rx_msg`. The new value appears after the second rising clock edge following the strobe of the candidate's last bit.
- R8: When a code is written, `irq` is high for exactly the clock in which the new `rx_msg` first appears, provided `irq_en` was high at the edge that wrote the code. With `irq_en` low the code is still written but no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Enables sending of the message codeword |
| tx_bit_stb | input | 1 | One-clock strobe per transmit data link bit |
| tx_bit | output | 1 | Transmit data link bit |
| tx_msg_wr | input | 1 | Write strobe for the transmit message register |
| tx_msg_wdata | input | 6 | Message code to send |
| rx_bit_stb | input | 1 | One-clock strobe marking a valid receive bit |
| rx_bit | input | 1 | Receive data link bit |
| rx_msg | output | 6 | Last accepted received message code |
| irq_en | input | 1 | Interrupt mask, 1 lets the pulse through |
| irq | output | 1 | One-clock pulse on a newly loaded message |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a transmit message write and the codeword boundary. The bench waits until the reference model is at position 15 with a strobe pending, writes in that clock, and expects the old code for one more codeword. The second pair is the receive load and a change of the interrupt mask. The bench toggles `irq_en` in the clock right after the last bit of the seventh matching candidate, and the pulse must follow the mask value sampled at the load edge. A behavioural model with queue-based history predicts `tx_bit`, `rx_msg` and `irq` for every clock.

// File: rtl/bom_pkg.sv
package bom_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_GRAB = 1'b1
    } rx_state_e;

endpackage

// File: rtl/bom_tx_framer.sv
module bom_tx_framer
    import bom_pkg::*;
#(
    parameter int MSG_W    = 6,
    parameter int FLAG_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_stb,
    input  logic             msg_wr,
    input  logic [MSG_W-1:0] msg_wdata,
    output logic             tx_bit
);
    localparam int CW    = FLAG_LEN + MSG_W + 2;
    localparam int CNT_W = $clog2(CW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

    tx_state_e        st, st_nx;
    logic [CNT_W-1:0] pos;
    logic [MSG_W-1:0] msg_q;
    logic [MSG_W-1:0] cur_msg;
    logic [CW-1:0]    cword;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // transitions: TX_START (idle -> send), TX_STOP (send -> idle)
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (en)  st_nx = TX_SEND;
            TX_SEND: if (!en) st_nx = TX_IDLE;
            default: st_nx = TX_IDLE;
        endcase
    end

    // message register and codeword position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q   <= '0;
            cur_msg <= '0;
            pos     <= '0;
        end else begin
            if (msg_wr) msg_q <= msg_wdata;
            unique case (st)
                TX_IDLE: begin
                    pos     <= '0;
                    cur_msg <= msg_q;
                end
                TX_SEND: begin
                    if (bit_stb) begin
                        if (pos == LAST) begin
                            pos     <= '0;
                            cur_msg <= msg_q;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
                default: pos <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        cword  = {{FLAG_LEN{1'b1}}, 1'b0, cur_msg, 1'b0};
        tx_bit = 1'b1;
        unique case (st)
            TX_IDLE: tx_bit = 1'b1;
            TX_SEND: tx_bit = cword[LAST - pos];
            default: tx_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/bom_rx_align.sv
module bom_rx_align
    import bom_pkg::*;
#(
    parameter int FLAG_LEN = 8,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    output logic              cand_stb,
    output logic [BYTE_W-1:0] cand_byte
);
    localparam int ONES_W = $clog2(FLAG_LEN + 1);
    localparam int GC_W   = $clog2(BYTE_W);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(FLAG_LEN);
    localparam logic [GC_W-1:0]   GC_LAST  = GC_W'(BYTE_W - 1);

    rx_state_e         st, st_nx;
    logic [ONES_W-1:0] ones;
    logic [GC_W-1:0]   gcnt;
    logic [BYTE_W-2:0] shreg;
    logic              flag_seen;
    logic              byte_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_HUNT;
        else        st <= st_nx;
    end

    // transitions: FLAG_SEEN (hunt -> grab), BYTE_DONE (grab -> hunt)
    always_comb begin
        flag_seen = (st == RX_HUNT) && bit_stb && !bit_in && (ones == ONES_MAX);
        byte_done = (st == RX_GRAB) && bit_stb && (gcnt == GC_LAST);
        st_nx     = st;
        unique case (st)
            RX_HUNT: if (flag_seen) st_nx = RX_GRAB;
            RX_GRAB: if (byte_done) st_nx = RX_HUNT;
            default: st_nx = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones      <= '0;
            gcnt      <= '0;
            shreg     <= '0;
            cand_stb  <= 1'b0;
            cand_byte <= '0;
        end else begin
            cand_stb <= 1'b0;
            unique case (st)
                RX_HUNT: begin
                    if (bit_stb) begin
                        if (bit_in) begin
                            if (ones != ONES_MAX) ones <= ones + 1'b1;
                        end else begin
                            // a zero always clears the run; after a full run it is bit 7
                            ones  <= '0;
                            shreg <= '0;
                            gcnt  <= GC_W'(1);
                        end
                    end
                end
                RX_GRAB: begin
                    if (bit_stb) begin
                        shreg <= {shreg[BYTE_W-3:0], bit_in};
                        gcnt  <= gcnt + 1'b1;
                        if (byte_done) begin
                            cand_byte <= {shreg, bit_in};
                            cand_stb  <= 1'b1;
                        end
                    end
                end
                default: ones <= '0;
            endcase
        end
    end

endmodule

// File: rtl/bom_rx_vote.sv
module bom_rx_vote #(
    parameter int MSG_W    = 6,
    parameter int DEPTH    = 10,
    parameter int VOTE_MIN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_stb,
    input  logic [MSG_W+1:0] cand_byte,
    input  logic             irq_en,
    output logic [MSG_W-1:0] rx_msg,
    output logic             irq
);
    localparam int OLD   = DEPTH - 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(VOTE_MIN);

    logic [OLD-1:0]   h_vld;
    logic [MSG_W-1:0] h_code [OLD];
    logic             new_vld;
    logic [MSG_W-1:0] new_code;
    logic [DEPTH-1:0] hit;
    logic [CNT_W-1:0] votes;
    logic             have;
    logic             load;

    assign new_vld  = !cand_byte[MSG_W+1] && !cand_byte[0];
    assign new_code = cand_byte[MSG_W:1];
    assign hit[0]   = new_vld;

    for (genvar g = 1; g < DEPTH; g++) begin : g_hit
        assign hit[g] = new_vld && h_vld[g-1] && (h_code[g-1] == new_code);
    end

    assign votes = CNT_W'($countones(hit));
    assign load  = cand_stb && new_vld && (votes >= NEED) &&
                   (!have || (new_code != rx_msg));

    // history: slot 0 holds the most recent older candidate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_vld     <= '0;
            h_code[0] <= '0;
        end else if (cand_stb) begin
            h_vld     <= {h_vld[OLD-2:0], new_vld};
            h_code[0] <= new_code;
        end
    end

    for (genvar g = 1; g < OLD; g++) begin : g_shift
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        h_code[g] <= '0;
            else if (cand_stb) h_code[g] <= h_code[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_msg <= '0;
            have   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                rx_msg <= new_code;
                have   <= 1'b1;
                irq    <= irq_en;
            end
        end
    end

endmodule

// File: rtl/bom_codec.sv
module bom_codec #(
    parameter int MSG_W      = 6,
    parameter int FLAG_LEN   = 8,
    parameter int HIST_DEPTH = 10,
    parameter int VOTE_MIN   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_bit_stb,
    output logic             tx_bit,
    input  logic             tx_msg_wr,
    input  logic [MSG_W-1:0] tx_msg_wdata,
    input  logic             rx_bit_stb,
    input  logic             rx_bit,
    output logic [MSG_W-1:0] rx_msg,
    input  logic             irq_en,
    output logic             irq
);
    localparam int BYTE_W = MSG_W + 2;

    logic              cand_stb;
    logic [BYTE_W-1:0] cand_byte;

    bom_tx_framer #(.MSG_W(MSG_W), .FLAG_LEN(FLAG_LEN)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .bit_stb   (tx_bit_stb),
        .msg_wr    (tx_msg_wr),
        .msg_wdata (tx_msg_wdata),
        .tx_bit    (tx_bit)
    );

    bom_rx_align #(.FLAG_LEN(FLAG_LEN), .BYTE_W(BYTE_W)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (rx_bit_stb),
        .bit_in    (rx_bit),
        .cand_stb  (cand_stb),
        .cand_byte (cand_byte)
    );

    bom_rx_vote #(.MSG_W(MSG_W), .DEPTH(HIST_DEPTH), .VOTE_MIN(VOTE_MIN)) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_stb  (cand_stb),
        .cand_byte (cand_byte),
        .irq_en    (irq_en),
        .rx_msg    (rx_msg),
        .irq       (irq)
    );

endmodule

// File: rtl/bom_codec_chk.sv
module bom_codec_chk #(
    parameter int MSG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             tx_bit,
    input logic             irq_en,
    input logic             irq,
    input logic [MSG_W-1:0] rx_msg,
    input logic             cand_stb
);

    AST_IDLE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_en) |-> tx_bit); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en)); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_MSG_FROM_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_msg) |-> $past(cand_stb)); // R7

    AST_CAND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cand_stb |=> !cand_stb); // R5

endmodule

bind bom_codec bom_codec_chk #(.MSG_W(MSG_W)) u_bom_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .irq_en   (irq_en),
    .irq      (irq),
    .rx_msg   (rx_msg),
    .cand_stb (cand_stb)
);

// File: tb/test_bom_codec.sv
module test_bom_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_bit_stb = 1'b0, tx_msg_wr = 1'b0;
    logic [5:0] tx_msg_wdata = '0;
    logic       rx_bit_stb = 1'b0, rx_bit = 1'b1, irq_en = 1'b1;
    logic       tx_bit, irq;
    logic [5:0] rx_msg;

    always #10 clk = ~clk;

    bom_codec i_bom_codec (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit_stb(tx_bit_stb),
        .tx_bit(tx_bit), .tx_msg_wr(tx_msg_wr), .tx_msg_wdata(tx_msg_wdata),
        .rx_bit_stb(rx_bit_stb), .rx_bit(rx_bit), .rx_msg(rx_msg),
        .irq_en(irq_en), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, irq_seen = 0, tcyc = 0;
    bit tx_run = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_pos, m_cur, m_msgq;
    int m_ones, m_grab, m_gcnt, m_shift, m_have, m_msg, pend_load, pend_msg, exp_irq;
    int hist[$];

    function automatic int cw_bit(input int p, input int msg);
        if (p < 8) return 1;
        if (p == 8 || p == 15) return 0;
        return (msg >> (14 - p)) & 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_cur = 0; m_msgq = 0;
            m_ones = 0; m_grab = 0; m_gcnt = 0; m_shift = 0;
            m_have = 0; m_msg = 0; pend_load = 0; pend_msg = 0; exp_irq = 0;
            hist.delete();
        end else begin
            if (m_st == 0) begin
                m_pos = 0; m_cur = m_msgq;
            end else if (tx_bit_stb) begin
                if (m_pos == 15) begin m_pos = 0; m_cur = m_msgq; end
                else m_pos++;
            end
            m_st = tx_en;
            if (tx_msg_wr) m_msgq = tx_msg_wdata;

            exp_irq = 0;
            if (pend_load) begin
                m_msg = pend_msg; m_have = 1; exp_irq = irq_en; pend_load = 0;
            end
            if (rx_bit_stb) begin
                if (!m_grab) begin
                    if (rx_bit) begin
                        if (m_ones < 8) m_ones++;
                    end else begin
                        if (m_ones == 8) begin m_grab = 1; m_gcnt = 1; m_shift = 0; end
                        m_ones = 0;
                    end
                end else begin
                    m_shift = (m_shift << 1) | int'(rx_bit);
                    m_gcnt++;
                    if (m_gcnt == 8) begin
                        int code, votes;
                        m_grab = 0; m_ones = 0;
                        code = (m_shift & 1) ? -1 : ((m_shift >> 1) & 63);
                        hist.push_front(code);
                        if (hist.size() > 10) void'(hist.pop_back());
                        votes = 0;
                        foreach (hist[i]) if (code >= 0 && hist[i] == code) votes++;
                        if (code >= 0 && votes >= 7 && (!m_have || code != m_msg)) begin
                            pend_load = 1; pend_msg = code;
                        end
                    end
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int e_tx;
            e_tx = (m_st != 0) ? cw_bit(m_pos, m_cur) : 1;
            chk(tx_bit == e_tx[0], (m_st != 0) ? "R3 R4 tx_bit" : "R2 tx_bit", tx_bit, e_tx);
            chk(rx_msg == m_msg[5:0], "R5 R6 R7 rx_msg", rx_msg, m_msg);
            chk(irq == exp_irq[0], "R8 irq", irq, exp_irq);
            if (irq) irq_seen++;
        end
    end

    // transmit strobe every fourth clock
    always @(posedge clk) begin
        #1;
        tcyc++;
        tx_bit_stb = tx_run && (tcyc % 4 == 0);
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input bit b, input int mask_after = -1);
        @(posedge clk); #1;
        rx_bit = b; rx_bit_stb = 1'b1;
        @(posedge clk); #1;
        rx_bit_stb = 1'b0;
        if (mask_after >= 0) irq_en = mask_after[0];
    endtask

    task automatic send_word(input int byte8, input int mask_after = -1, input int nflag = 8);
        for (int i = 0; i < nflag; i++) send_bit(1'b1);
        for (int i = 7; i >= 0; i--) send_bit(byte8[i], (i == 0) ? mask_after : -1);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic write_msg(input int v);
        @(posedge clk); #1;
        tx_msg_wr = 1'b1; tx_msg_wdata = v[5:0];
        @(posedge clk); #1;
        tx_msg_wr = 1'b0;
    endtask

    task automatic write_at_boundary(input int v);
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #2;
            if (tx_bit_stb && m_st != 0 && m_pos == 15) break;
        end
        tx_msg_wr = 1'b1; tx_msg_wdata = v[5:0];
        @(posedge clk); #1;
        tx_msg_wr = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(tx_bit == 1'b1, "R1 reset tx_bit", tx_bit, 1);
        chk(rx_msg == 6'h0, "R1 reset rx_msg", rx_msg, 0);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        @(negedge clk); rst_n = 1'b1;

        // transmit path runs in the background
        write_msg(6'h2D);
        tx_run = 1; tx_en = 1'b1;
        repeat (150) @(posedge clk);
        #1 write_msg(6'h13);          // mid-codeword write: R4
        repeat (100) @(posedge clk);
        #1 tx_en = 1'b0;              // stop mid-codeword: R2
        repeat (20) @(posedge clk);
        #1 tx_en = 1'b1;
        write_at_boundary(6'h2A);     // write on the boundary strobe: R4

        // R6: six matches are not enough, the seventh loads
        for (int i = 0; i < 6; i++) send_word(8'h5A);
        settle();
        chk(rx_msg == 6'h0 && irq_seen == 0, "R6 six of ten", rx_msg, 0);
        send_word(8'h5A);
        settle();
        chk(rx_msg == 6'h2D, "R6 seventh loads", rx_msg, 6'h2D);
        chk(irq_seen == 1, "R8 pulse count", irq_seen, 1);

        // R7: repeated identical code gives no new load
        for (int i = 0; i < 5; i++) send_word(8'h5A);
        settle();
        chk(irq_seen == 1, "R7 no reload", irq_seen, 1);

        // R5: invalid candidate counts as non-match
        for (int i = 0; i < 3; i++) send_word(8'h26);
        send_word(8'h27);
        for (int i = 0; i < 3; i++) send_word(8'h26);
        settle();
        chk(rx_msg == 6'h2D, "R5 invalid entry blocks vote", rx_msg, 6'h2D);
        send_word(8'h26);
        settle();
        chk(rx_msg == 6'h13, "R5 R6 load after noise", rx_msg, 6'h13);
        chk(irq_seen == 2, "R8 second pulse", irq_seen, 2);

        // R5: seven-one runs never align
        for (int i = 0; i < 10; i++) send_word(8'h02, -1, 7);
        settle();
        chk(rx_msg == 6'h13, "R5 short run ignored", rx_msg, 6'h13);

        // R8: masked load still writes the register
        irq_en = 1'b0;
        for (int i = 0; i < 7; i++) send_word(8'h7E);
        settle();
        chk(rx_msg == 6'h3F, "R8 masked load", rx_msg, 6'h3F);
        chk(irq_seen == 2, "R8 masked no pulse", irq_seen, 2);

        // R8: mask raised in the load clock lets the pulse out
        for (int i = 0; i < 6; i++) send_word(8'h0C);
        send_word(8'h0C, 1);
        settle();
        chk(rx_msg == 6'h06, "R7 load with mask change", rx_msg, 6'h06);
        chk(irq_seen == 3, "R8 mask set at load edge", irq_seen, 3);

        // R8: mask dropped in the load clock suppresses it
        for (int i = 0; i < 6; i++) send_word(8'h42);
        send_word(8'h42, 0);
        settle();
        chk(rx_msg == 6'h21, "R7 load with mask drop", rx_msg, 6'h21);
        chk(irq_seen == 3, "R8 mask cleared at load edge", irq_seen, 3);

        write_at_boundary(6'h05);
        repeat (200) @(posedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

endmodule